// File: doc/BRIEF.md
# Packed Subword SIMD ALU

This block is a 64-bit arithmetic unit that views each operand as a row of equal-width lanes and applies one operation to every lane in the same cycle. A lane-size select picks 8-bit, 16-bit or 32-bit lanes, so a single operand holds eight, four or two independent values. The supported operations are a lane-wise wrapping add, a signed multiply with pairwise accumulation into double-width lanes, a narrowing pack that merges two operands, and a widening unpack that spreads the low lanes of one operand.

The datapath is purely combinational. A parameter places an optional register stage on the result and the illegal flag. With the default setting the outputs change on the clock edge that follows the operands. Any opcode and lane-size pairing outside the supported set returns a zero result and raises the illegal flag. It does not stall or hold the previous value.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, with the output register present (`OUT_REG=1`, the default), `res_o` and `illegal_o` read zero.
- R2: With `OUT_REG=1`, operands driven in one cycle appear on `res_o` after the next rising clock edge, and the outputs keep the previous result until that edge. With `OUT_REG=0` the outputs follow the inputs in the same cycle.
- R3: Opcode 0 (add) with lane select 0 (8-bit) gives result byte i = (a byte i + b byte i) mod 256 for all eight bytes. No carry crosses a byte boundary.
- R4: Opcode 0 with lane select 1 (16-bit) or 2 (32-bit) gives each lane the sum of the matching input lanes, modulo 2^16 or 2^32 respectively.
- R5: Opcode 1 (multiply-add) with lane select 1 reads the operands as four signed 16-bit lanes. Result bits [32j+31:32j] equal a(2j)·b(2j) + a(2j+1)·b(2j+1) modulo 2^32, for j = 0 and 1.
- R6: Opcode 2 (pack) with lane select 1 truncates the four 16-bit lanes of a to their low bytes in result bytes 0..3, and those of b in bytes 4..7. With lane select 2 it truncates the 32-bit lanes of a to 16 bits in result lanes 0..1 (bits 31:0), and those of b in lanes 2..3.
- R7: Opcode 3 (unpack) with lane select 0 zero-extends bytes 0..3 of a into four 16-bit result lanes. With lane select 1 it zero-extends 16-bit lanes 0..1 of a into two 32-bit result lanes. Operand b is ignored.
- R8: Lane select 3 with any opcode, multiply-add with lane select other than 1, pack with lane select 0, and unpack with lane select 2 are illegal. Each gives `res_o` = 0 and `illegal_o` = 1. Every legal pairing gives `illegal_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation: 0 add, 1 multiply-add, 2 pack, 3 unpack |
| lsz_i | input | 2 | Lane size: 0 8-bit, 1 16-bit, 2 32-bit, 3 reserved |
| src_a_i | input | 64 | First packed operand |
| src_b_i | input | 64 | Second packed operand |
| res_o | output | 64 | Packed result |
| illegal_o | output | 1 | Unsupported opcode and lane-size pairing |

## Verification
The only state in this block is the output register, so a fault there appears at the ports one clock edge after the operands. A corrupted lane, a stale hold or a missed reset clear shows up on the very next sample. Faults in the combinational lane logic appear as a wrong bit pattern in a specific lane. A carry leaking across a lane boundary changes the lowest bit of the next lane up, and a misrouted pack or unpack places bytes in the wrong half. Sweeping every opcode and lane-size pairing against carry-heavy and sign-heavy operands exposes such faults in the first affected result.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MADD = 2'd1,
        OP_PACK = 2'd2,
        OP_UNPK = 2'd3
    } simd_op_e;

    typedef enum logic [1:0] {
        LS_B8  = 2'd0,
        LS_H16 = 2'd1,
        LS_W32 = 2'd2,
        LS_RSV = 2'd3
    } simd_lsz_e;

endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  simd_lsz_e         lsz_i,
    output logic [DATA_W-1:0] sum_o
);
    localparam int NSZ = 3;

    for (genvar g = 0; g < NSZ; g++) begin : g_sz
        localparam int LW = 8 << g;
        localparam int NL = DATA_W / LW;
        logic [DATA_W-1:0] s;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            // each lane has its own adder: carries stop at the lane edge
            assign s[i*LW +: LW] = a_i[i*LW +: LW] + b_i[i*LW +: LW];
        end
    end

    always_comb begin
        unique case (lsz_i)
            LS_B8:   sum_o = g_sz[0].s;
            LS_H16:  sum_o = g_sz[1].s;
            LS_W32:  sum_o = g_sz[2].s;
            default: sum_o = '0;
        endcase
    end
endmodule

// File: rtl/simd_madd.sv
module simd_madd #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] acc_o
);
    localparam int IW = 16;
    localparam int OW = 2 * IW;
    localparam int NP = DATA_W / OW;

    for (genvar j = 0; j < NP; j++) begin : g_pair
        logic signed [IW-1:0] a0, a1, b0, b1;
        logic signed [OW-1:0] p0, p1;
        assign a0 = a_i[j*OW      +: IW];
        assign a1 = a_i[j*OW + IW +: IW];
        assign b0 = b_i[j*OW      +: IW];
        assign b1 = b_i[j*OW + IW +: IW];
        assign p0 = OW'(a0) * OW'(b0);
        assign p1 = OW'(a1) * OW'(b1);
        assign acc_o[j*OW +: OW] = p0 + p1;
    end
endmodule

// File: rtl/simd_perm.sv
module simd_perm
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              unpk_i,
    input  simd_lsz_e         lsz_i,
    output logic [DATA_W-1:0] out_o
);
    localparam int HALF = DATA_W / 2;

    // narrowing: source lanes of 16 (g=0) or 32 (g=1) bits
    for (genvar g = 0; g < 2; g++) begin : g_pk
        localparam int SW = 16 << g;
        localparam int HW = SW / 2;
        localparam int NL = DATA_W / SW;
        logic [DATA_W-1:0] v;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            assign v[i*HW        +: HW] = a_i[i*SW +: HW];
            assign v[HALF + i*HW +: HW] = b_i[i*SW +: HW];
        end
    end

    // widening: source lanes of 8 (g=0) or 16 (g=1) bits, low half of a
    for (genvar g = 0; g < 2; g++) begin : g_up
        localparam int SW = 8 << g;
        localparam int NL = HALF / SW;
        logic [DATA_W-1:0] v;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            assign v[i*2*SW +: 2*SW] = {{SW{1'b0}}, a_i[i*SW +: SW]};
        end
    end

    always_comb begin
        out_o = '0;
        if (unpk_i) begin
            unique case (lsz_i)
                LS_B8:   out_o = g_up[0].v;
                LS_H16:  out_o = g_up[1].v;
                default: out_o = '0;
            endcase
        end else begin
            unique case (lsz_i)
                LS_H16:  out_o = g_pk[0].v;
                LS_W32:  out_o = g_pk[1].v;
                default: out_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [1:0]        lsz_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              illegal_o
);
    simd_op_e          op;
    simd_lsz_e         lsz;
    logic [DATA_W-1:0] add_r, madd_r, perm_r;
    logic [DATA_W-1:0] res_d;
    logic              ill_d;

    assign op  = simd_op_e'(op_i);
    assign lsz = simd_lsz_e'(lsz_i);

    simd_lane_add #(.DATA_W(DATA_W)) u_add (
        .a_i(src_a_i), .b_i(src_b_i), .lsz_i(lsz), .sum_o(add_r)
    );

    simd_madd #(.DATA_W(DATA_W)) u_madd (
        .a_i(src_a_i), .b_i(src_b_i), .acc_o(madd_r)
    );

    simd_perm #(.DATA_W(DATA_W)) u_perm (
        .a_i(src_a_i), .b_i(src_b_i), .unpk_i(op == OP_UNPK),
        .lsz_i(lsz), .out_o(perm_r)
    );

    // legality of the opcode / lane-size pairing
    always_comb begin
        unique case (op)
            OP_ADD:  ill_d = (lsz == LS_RSV);
            OP_MADD: ill_d = (lsz != LS_H16);
            OP_PACK: ill_d = (lsz == LS_B8) || (lsz == LS_RSV);
            OP_UNPK: ill_d = (lsz == LS_W32) || (lsz == LS_RSV);
            default: ill_d = 1'b1;
        endcase
    end

    always_comb begin
        res_d = '0;
        if (!ill_d) begin
            unique case (op)
                OP_ADD:  res_d = add_r;
                OP_MADD: res_d = madd_r;
                default: res_d = perm_r;
            endcase
        end
    end

    if (OUT_REG) begin : g_oreg
        logic [DATA_W-1:0] res_q;
        logic              ill_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
                ill_q <= 1'b0;
            end else begin
                res_q <= res_d;
                ill_q <= ill_d;
            end
        end
        assign res_o     = res_q;
        assign illegal_o = ill_q;
    end else begin : g_comb
        assign res_o     = res_d;
        assign illegal_o = ill_d;
    end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic [1:0]        lsz_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic [DATA_W-1:0] res_o,
    input logic              illegal_o
);
    logic              primed;
    logic [1:0]        op_s, lsz_s;
    logic [DATA_W-1:0] a_s, b_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    if (OUT_REG) begin : g_lag
        always_ff @(posedge clk) begin
            op_s  <= op_i;
            lsz_s <= lsz_i;
            a_s   <= src_a_i;
            b_s   <= src_b_i;
        end
    end else begin : g_now
        assign op_s  = op_i;
        assign lsz_s = lsz_i;
        assign a_s   = src_a_i;
        assign b_s   = src_b_i;
    end

    logic signed [31:0] mx0, mx1;
    assign mx0 = 32'(signed'(a_s[15:0]))  * 32'(signed'(b_s[15:0]));
    assign mx1 = 32'(signed'(a_s[31:16])) * 32'(signed'(b_s[31:16]));

    a_r3_add_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (op_s == 2'd0 && lsz_s == 2'd0) |->
            (res_o[7:0] == 8'(a_s[7:0] + b_s[7:0]) &&
             res_o[15:8] == 8'(a_s[15:8] + b_s[15:8])));

    a_r5_madd_pair0: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (op_s == 2'd1 && lsz_s == 2'd1) |-> (res_o[31:0] == 32'(mx0 + mx1)));

    a_r6_pack_b_high: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (op_s == 2'd2 && lsz_s == 2'd1) |->
            (res_o[DATA_W/2 +: 8] == b_s[7:0] && res_o[7:0] == a_s[7:0]));

    a_r7_unpack_zero_ext: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (op_s == 2'd3 && lsz_s == 2'd0) |->
            (res_o[15:8] == 8'h00 && res_o[7:0] == a_s[7:0]));

    a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        illegal_o |-> (res_o == '0));

    a_r8_madd_width: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (op_s == 2'd1 && lsz_s != 2'd1) |-> illegal_o);

    a_r8_reserved_size: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (lsz_s == 2'd3) |-> illegal_o);
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lsz_i(lsz_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .res_o(res_o), .illegal_o(illegal_o)
);

// File: tb/simd_alu_tb.sv
`timescale 1ns/1ps
module simd_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op = '0, lsz = '0;
    logic [63:0] a = '0, b = '0;
    logic [63:0] res;
    logic        ill;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    simd_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .lsz_i(lsz),
        .src_a_i(a), .src_b_i(b), .res_o(res), .illegal_o(ill)
    );

    // expected {illegal, result} from the requirement text
    function automatic logic [64:0] model(int o, int s, logic [63:0] x, logic [63:0] y);
        logic [63:0] r = '0;
        logic [63:0] m;
        int w;
        longint acc;
        if (s == 3 || (o == 1 && s != 1) || (o == 2 && s == 0) || (o == 3 && s == 2))
            return {1'b1, 64'd0};
        case (o)
            0: begin                                   // R3 / R4
                w = 8 << s;
                m = (64'd1 << w) - 1;
                for (int i = 0; i < 64 / w; i++)
                    r |= ((((x >> (i*w)) & m) + ((y >> (i*w)) & m)) & m) << (i*w);
            end
            1: begin                                   // R5
                for (int j = 0; j < 2; j++) begin
                    acc = longint'(signed'(x[j*32 +: 16])) * longint'(signed'(y[j*32 +: 16]))
                        + longint'(signed'(x[j*32+16 +: 16])) * longint'(signed'(y[j*32+16 +: 16]));
                    r |= (64'(acc) & 64'hFFFF_FFFF) << (j*32);
                end
            end
            2: begin                                   // R6
                w = 8 << s;
                m = (64'd1 << (w/2)) - 1;
                for (int i = 0; i < 64 / w; i++) begin
                    r |= ((x >> (i*w)) & m) << (i*w/2);
                    r |= ((y >> (i*w)) & m) << (32 + i*w/2);
                end
            end
            default: begin                             // R7
                w = 8 << s;
                m = (64'd1 << w) - 1;
                for (int i = 0; i < 32 / w; i++)
                    r |= ((x >> (i*w)) & m) << (i*2*w);
            end
        endcase
        return {1'b0, r};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(int o, int s, bit il);
        if (il) return "R8";
        case (o)
            0: return (s == 0) ? "R3" : "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_op(int o, int s, logic [63:0] x, logic [63:0] y);
        logic [64:0] e;
        @(negedge clk);
        op = 2'(o); lsz = 2'(s); a = x; b = y;
        e = model(o, s, x, y);
        @(negedge clk);
        check(tag_of(o, s, e[64]), res, e[63:0]);
        check(tag_of(o, s, e[64]), 64'(ill), 64'(e[64]));
    endtask

    logic [63:0] pat [12];

    initial begin
        logic [63:0] xs;
        logic [64:0] e1, e2;
        pat[0] = 64'h0;
        pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pat[2] = 64'h8000_7FFF_8000_7FFF;
        pat[3] = 64'h0123_4567_89AB_CDEF;
        pat[4] = 64'hFF00_FF00_FF00_FF00;
        pat[5] = 64'h7F80_01FF_8001_FFFE;
        xs = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 6; k < 12; k++) begin
            xs ^= xs << 13; xs ^= xs >> 7; xs ^= xs << 17;
            pat[k] = xs;
        end

        // R1: reset clears outputs while a legal op is presented
        op = 2'd0; lsz = 2'd0; a = 64'h1111_2222_3333_4444; b = 64'h0101_0101_0101_0101;
        repeat (3) @(negedge clk);
        check("R1", res, 64'd0);
        check("R1", 64'(ill), 64'd0);
        rst_n = 1'b1;

        // R2: result held until the next edge, then updated
        run_op(0, 1, pat[3], pat[4]);
        e1 = model(0, 1, pat[3], pat[4]);
        op = 2'd3; lsz = 2'd0; a = pat[5]; b = pat[1];
        e2 = model(3, 0, pat[5], pat[1]);
        #1;
        check("R2", res, e1[63:0]);
        @(negedge clk);
        check("R2", res, e2[63:0]);

        // all opcode / lane-size pairings over the pattern set (R3..R8)
        for (int o = 0; o < 4; o++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 12; k++)
                    run_op(o, s, pat[k], pat[(k*5 + 3) % 12]);

        // R3: byte-lane carry isolation over every value of a
        for (int v = 0; v < 256; v++)
            run_op(0, 0, {8{8'(v)}}, {8{8'((v*37 + 11) & 255)}});

        // R7: operand b has no effect on unpack
        run_op(3, 1, pat[3], 64'd0);
        run_op(3, 1, pat[3], 64'hFFFF_FFFF_FFFF_FFFF);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule